// File: doc/BRIEF.md
# Register-Controlled SPI Master Engine

This block is a byte-wide SPI master that software runs through three memory-mapped registers: a control register, a status register and a data register. Writing a start bit in the control register launches one transfer. A write transfer shifts the data register out to the slave. A read transfer shifts one byte in from the slave and stores it in the data register. A combined transaction does a write followed by a read, and it holds BUSY high for the whole of both bytes. All transfers are mode 0 (SCLK idles low, data is sampled on the rising edge and changed on the falling edge) and send the most significant bit first. A divider field in the control register sets the SCLK rate.

The chip-select pin is a plain level that software sets through a control bit. The block never frames chip select around a transfer, so software can keep the slave selected across several bytes. The data-out pin has its own output-enable. It is released for the whole of every read byte. After a write it is either held at the last bit sent or released, depending on a control bit.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, the control, status and data registers read 0, `spi_cs_n` is 1, `spi_sclk` is 0, and `spi_mosi_oe` is 1.
- R2: The data register (offset 0x8) holds 8 bits in bits 7:0. Bits 31:8 read as 0 whatever value was written.
- R3: Writing control (offset 0x0) with bit 1 = 1 shifts the data register out on `spi_mosi` MSB first with exactly 8 SCLK pulses. SCLK idles low and `spi_mosi` changes only while SCLK is low. A control write whose bits 3:1 are all 0 starts nothing.
- R4: Writing control with bit 2 = 1 (and bits 1 and 3 = 0) samples `spi_miso` on 8 rising SCLK edges, MSB first, and places the byte in the data register.
- R5: Control bits 1, 2 and 3 are write-only strobes and always read back as 0.
- R6: Status bit 0 (offset 0x4) is BUSY. It reads 1 from the cycle after the starting write and stays 1 for exactly 16×(DIV+1) clock cycles per byte transferred. It does not rise without a start write.
- R7: Control bits 15:8 hold DIV. Each SCLK half period lasts DIV+1 clock cycles, and DIV reads back as written.
- R8: During a read byte, `spi_mosi_oe` is 0 at every SCLK edge. After a read or combined transaction it stays 0 until the next write byte begins.
- R9: After a write transfer, control bit 4 = 1 makes `spi_mosi_oe` 0. Bit 4 = 0 keeps `spi_mosi_oe` at 1, with `spi_mosi` held at the last bit sent (bit 0 of the data).
- R10: `spi_cs_n` is the inverse of control bit 0 from the cycle after a control write. Transfers never change it.
- R11: While BUSY is 1, start bits, data-register writes and DIV writes are ignored. Control bits 0 and 4 still update.
- R12: When several start bits are written together, the combined transaction (bit 3) wins, then write (bit 1), then read (bit 2).
- R13: Control bit 3 = 1 sends the data register and then reads one byte into it, using 16 SCLK pulses in one unbroken BUSY period of 32×(DIV+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write access |
| bus_addr | input | 4 | Byte address (0x0 control, 0x4 status, 0x8 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to slave |
| spi_mosi_oe | output | 1 | Output enable for `spi_mosi` pad |
| spi_miso | input | 1 | Serial data from slave |

## Verification
The hardest situation to reach is a register access that arrives in the middle of a transfer. A start request, a data write or a divider change that lands while BUSY is high must leave the running byte, the stored data and the SCLK timing untouched. The stimulus reaches this by polling the status register every cycle of a transfer and, at a chosen cycle, issuing a data write and a control write that carries a different start bit and a different divider. The bench then checks the BUSY length, the SCLK count, the data the slave captured, and the register contents. Randomized transfer kinds, dividers and tri-state settings, mixed with colliding start bits, cover the priority order and the output-enable behaviour after each kind of transfer.

// File: rtl/spi_ctl_pkg.sv
// Package: shared register layout and state types for the SPI master engine.
// Assumes a 32-bit register bus with word addresses decoded from bits 3:2.
package spi_ctl_pkg;

    // Control register bit positions
    localparam int CTRL_CS      = 0;
    localparam int CTRL_WR      = 1;
    localparam int CTRL_RD      = 2;
    localparam int CTRL_SEQ     = 3;
    localparam int CTRL_HIZ     = 4;
    localparam int CTRL_DIV_LSB = 8;

    // Word selects (bus_addr[3:2])
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    // Engine phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2
    } phase_t;

    // Start request decoded from a control write
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_WR   = 2'd1,
        REQ_RD   = 2'd2,
        REQ_SEQ  = 2'd3
    } req_t;

endpackage

// File: rtl/spi_ctl_regs.sv
// Module: register file of the SPI master. It holds chip-select, tri-state
// policy, divider and data, decodes start strobes into one prioritised request,
// and returns read data combinationally.
// Assumes: a single-cycle bus write (bus_sel & bus_we) and that busy comes
// from the shift engine.
module spi_ctl_regs
    import spi_ctl_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int XFER_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              rx_done,
    input  logic [XFER_W-1:0] rx_byte,
    output req_t              req,
    output logic              cs_en,
    output logic              hiz,
    output logic [DIV_W-1:0]  div,
    output logic [XFER_W-1:0] data_q
);

    localparam int DIV_HI = CTRL_DIV_LSB + DIV_W;

    logic wr_ctrl, wr_data;
    logic unused_bits;

    assign wr_ctrl = bus_sel & bus_we & (bus_addr[3:2] == SEL_CTRL);
    assign wr_data = bus_sel & bus_we & (bus_addr[3:2] == SEL_DATA);
    assign unused_bits = ^{bus_wdata[BUS_W-1:DIV_HI],
                           bus_wdata[CTRL_DIV_LSB-1:CTRL_HIZ+1], bus_addr[1:0]};

    // Turn a control write into one start request: combined > write > read
    always_comb begin
        req = REQ_NONE;
        if (wr_ctrl && !busy) begin
            if (bus_wdata[CTRL_SEQ])     req = REQ_SEQ;
            else if (bus_wdata[CTRL_WR]) req = REQ_WR;
            else if (bus_wdata[CTRL_RD]) req = REQ_RD;
        end
    end

    // Level control bits: always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_en <= 1'b0;
            hiz   <= 1'b0;
        end else if (wr_ctrl) begin
            cs_en <= bus_wdata[CTRL_CS];
            hiz   <= bus_wdata[CTRL_HIZ];
        end
    end

    // Divider: frozen while a transfer runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            div <= '0;
        else if (wr_ctrl && !busy)
            div <= bus_wdata[CTRL_DIV_LSB +: DIV_W];
    end

    // Data register: received byte wins; bus writes only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (rx_done)
            data_q <= rx_byte;
        else if (wr_data && !busy)
            data_q <= bus_wdata[XFER_W-1:0];
    end

    // Read-back multiplexer; strobes and reserved bits return 0
    always_comb begin
        bus_rdata = '0;
        case (bus_addr[3:2])
            SEL_CTRL: begin
                bus_rdata[CTRL_CS]                = cs_en;
                bus_rdata[CTRL_HIZ]               = hiz;
                bus_rdata[CTRL_DIV_LSB +: DIV_W]  = div;
            end
            SEL_STAT: bus_rdata[0] = busy;
            SEL_DATA: bus_rdata[XFER_W-1:0] = data_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_ctl_clkdiv.sv
// Module: half-period tick generator. While run is high it emits one tick
// every div+1 clock cycles; while run is low the count is held at zero so
// the first tick of a transfer comes a full half period after the start.
module spi_ctl_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Count cycles within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_ctl_shifter.sv
// Module: mode-0 shift engine. It runs a write byte, a read byte, or a write
// byte followed by a read byte, stepping on divider ticks. It also drives
// SCLK, MOSI and the MOSI output-enable.
// Assumes: req is only non-NONE while idle (gated in the register file).
module spi_ctl_shifter
    import spi_ctl_pkg::*;
#(
    parameter int XFER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_t              req,
    input  logic [XFER_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              hiz,
    input  logic              spi_miso,
    output logic              busy,
    output logic              rd_phase,
    output logic              rx_done,
    output logic [XFER_W-1:0] rx_byte,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_mosi_oe
);

    localparam int CNT_W = (XFER_W > 1) ? $clog2(XFER_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(XFER_W - 1);

    phase_t             phase_q;
    logic               seq_q, sclk_q, last_rd_q;
    logic [CNT_W-1:0]   bit_q;
    logic [XFER_W-1:0]  tx_q, rx_q;
    logic               fall_tick, rise_tick, byte_end;

    assign rise_tick = tick && !sclk_q;
    assign fall_tick = tick && sclk_q;
    assign byte_end  = fall_tick && (bit_q == LAST_BIT);

    // Phase sequencing, SCLK toggling and bit counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            seq_q   <= 1'b0;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req != REQ_NONE) begin
                        phase_q <= (req == REQ_RD) ? PH_RD : PH_WR;
                        seq_q   <= (req == REQ_SEQ);
                        bit_q   <= '0;
                        sclk_q  <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        if (sclk_q) begin
                            if (bit_q == LAST_BIT) begin
                                bit_q <= '0;
                                if (phase_q == PH_WR && seq_q) begin
                                    phase_q <= PH_RD;
                                end else begin
                                    phase_q <= PH_IDLE;
                                    seq_q   <= 1'b0;
                                end
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Shift registers: load on write start, shift out on falling, sample on rising
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (phase_q == PH_IDLE && (req == REQ_WR || req == REQ_SEQ))
                tx_q <= tx_byte;
            else if (phase_q == PH_WR && fall_tick && bit_q != LAST_BIT)
                tx_q <= {tx_q[XFER_W-2:0], 1'b0};
            if (phase_q != PH_IDLE && rise_tick)
                rx_q <= {rx_q[XFER_W-2:0], spi_miso};
        end
    end

    // Remember whether the most recent byte was a read (keeps MOSI released)
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_rd_q <= 1'b0;
        else if (phase_q == PH_RD)
            last_rd_q <= 1'b1;
        else if (phase_q == PH_WR)
            last_rd_q <= 1'b0;
    end

    assign busy        = (phase_q != PH_IDLE);
    assign rd_phase    = (phase_q == PH_RD);
    assign rx_done     = rd_phase && byte_end;
    assign rx_byte     = rx_q;
    assign spi_sclk    = sclk_q;
    assign spi_mosi    = tx_q[XFER_W-1];
    assign spi_mosi_oe = (phase_q == PH_WR) ||
                         ((phase_q == PH_IDLE) && !last_rd_q && !hiz);

endmodule

// File: rtl/spi_ctl_top.sv
// Module: top of the register-controlled SPI master. It ties the register
// file, the divider and the shift engine together and turns the chip-select
// level into the active-low pin.
// Assumes: one register access per cycle; read data valid combinationally.
module spi_ctl_top
    import spi_ctl_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int XFER_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    output logic             spi_mosi_oe,
    input  logic             spi_miso
);

    req_t              req;
    logic              xfer_busy, rd_phase, rx_done, tick;
    logic              cs_en, hiz;
    logic [DIV_W-1:0]  div;
    logic [XFER_W-1:0] data_byte, rx_byte;

    spi_ctl_regs #(
        .BUS_W (BUS_W),
        .XFER_W(XFER_W),
        .DIV_W (DIV_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (xfer_busy),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .req      (req),
        .cs_en    (cs_en),
        .hiz      (hiz),
        .div      (div),
        .data_q   (data_byte)
    );

    spi_ctl_clkdiv #(
        .DIV_W(DIV_W)
    ) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (xfer_busy),
        .div  (div),
        .tick (tick)
    );

    spi_ctl_shifter #(
        .XFER_W(XFER_W)
    ) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .tx_byte    (data_byte),
        .tick       (tick),
        .hiz        (hiz),
        .spi_miso   (spi_miso),
        .busy       (xfer_busy),
        .rd_phase   (rd_phase),
        .rx_done    (rx_done),
        .rx_byte    (rx_byte),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_mosi_oe(spi_mosi_oe)
    );

    assign spi_cs_n = ~cs_en;

endmodule

// File: rtl/spi_ctl_chk.sv
// Module: assertion checker for spi_ctl_top, attached by bind. It watches the
// bus, the SPI pins and a few internal handshakes.
module spi_ctl_chk #(
    parameter int BUS_W  = 32,
    parameter int XFER_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [3:0]        bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              busy,
    input logic              rd_phase,
    input logic              rx_done,
    input logic [XFER_W-1:0] data_q,
    input logic              spi_sclk,
    input logic              spi_cs_n,
    input logic              spi_mosi,
    input logic              spi_mosi_oe
);

    logic ctrl_wr, data_wr, unused_chk;

    assign ctrl_wr = bus_sel && bus_we && (bus_addr == 4'h0);
    assign data_wr = bus_sel && bus_we && (bus_addr == 4'h8);
    assign unused_chk = ^bus_wdata[BUS_W-1:4];

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr && (bus_wdata[3:1] != 3'b000)));

    // R8
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase |-> !spi_mosi_oe);

    // R10
    cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (spi_cs_n == !$past(bus_wdata[0])));

    // R11
    data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_wr && !rx_done) |=> (data_q == $past(data_q)));

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

endmodule

bind spi_ctl_top spi_ctl_chk #(
    .BUS_W (BUS_W),
    .XFER_W(XFER_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (xfer_busy),
    .rd_phase   (rd_phase),
    .rx_done    (rx_done),
    .data_q     (data_byte),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_mosi_oe(spi_mosi_oe)
);

// File: tb/spi_ctl_tb.sv
`timescale 1ns/1ps
// Bench for spi_ctl_top: directed corner cases plus seeded random transfers,
// against a behavioural mode-0 slave and expected values from bench functions.
module spi_ctl_top_tb_top;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_DATA = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_mosi_oe, spi_miso;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Slave model state
    int          sclk_cnt = 0;
    int          oe_hi_cnt = 0;
    int          slv_base = 0;
    int          slv_idx;
    logic [15:0] slv_pat = '0;
    logic [15:0] slv_rx = '0;

    always #10 clk = ~clk;

    spi_ctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso)
    );

    // Slave presents pattern MSB first; advances after each rising SCLK
    assign slv_idx  = 15 - (sclk_cnt - slv_base);
    assign spi_miso = (slv_idx >= 0 && slv_idx <= 15) ? slv_pat[slv_idx[3:0]] : 1'b0;

    always @(posedge spi_sclk) begin
        slv_rx    <= {slv_rx[14:0], spi_mosi};
        sclk_cnt  <= sclk_cnt + 1;
        oe_hi_cnt <= oe_hi_cnt + (spi_mosi_oe ? 1 : 0);
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // 0 = write, 1 = read, 2 = combined; priority combined > write > read
    function automatic int eff_kind(input logic [3:1] sb);
        if (sb[3]) return 2;
        if (sb[1]) return 0;
        return 1;
    endfunction

    function automatic int exp_busy(input int k, input int dv);
        return ((k == 2) ? 32 : 16) * (dv + 1);
    endfunction

    function automatic logic [7:0] exp_data(input int k, input logic [7:0] d,
                                            input logic [15:0] p);
        if (k == 0) return d;
        if (k == 1) return p[15:8];
        return p[7:0];
    endfunction

    function automatic logic [31:0] ctrl_word(input int dv, input bit hz);
        return (32'(dv) << 8) | (32'(hz) << 4) | 32'h1;
    endfunction

    // One transfer with full checking; poke issues ignored writes mid-transfer
    task automatic do_xfer(input logic [3:1] sb, input logic [7:0] d,
                           input logic [15:0] p, input int dv, input bit hz,
                           input bit poke, input string tag);
        int k, n, s0, o0;
        logic [31:0] r;
        k = eff_kind(sb);
        bus_write(A_DATA, {24'hABCDEF, d});
        bus_write(A_CTRL, ctrl_word(dv, hz));
        slv_pat = p; slv_base = sclk_cnt; s0 = sclk_cnt; o0 = oe_hi_cnt;
        bus_write(A_CTRL, ctrl_word(dv, hz) | {28'h0, sb, 1'b0});
        bus_read(A_STAT, r);
        chk(r[0] == 1'b1, "R6", {tag, " busy after start"}, r, 32'h1);
        n = 0;
        while (1) begin
            bus_read(A_STAT, r);
            if (!r[0]) break;
            n++;
            if (poke && n == 2) begin
                bus_write(A_DATA, 32'h0000005A);
                bus_write(A_CTRL, ctrl_word(dv + 1, hz) | 32'h4);
                n++;
            end else begin
                @(negedge clk);
            end
        end
        chk(n == exp_busy(k, dv), "R6", {tag, " busy cycles"}, n, exp_busy(k, dv));
        chk(sclk_cnt - s0 == ((k == 2) ? 16 : 8), "R13", {tag, " sclk pulses"},
            sclk_cnt - s0, (k == 2) ? 16 : 8);
        if (k == 0)
            chk(slv_rx[7:0] == d, "R3", {tag, " slave got byte"}, slv_rx[7:0], d);
        if (k == 2)
            chk(slv_rx[15:8] == d, "R13", {tag, " slave got first byte"}, slv_rx[15:8], d);
        bus_read(A_DATA, r);
        chk(r == {24'h0, exp_data(k, d, p)}, (k == 0) ? "R12" : "R4",
            {tag, " data reg"}, r, {24'h0, exp_data(k, d, p)});
        chk(oe_hi_cnt - o0 == ((k == 1) ? 0 : 8), "R8", {tag, " oe at sclk edges"},
            oe_hi_cnt - o0, (k == 1) ? 0 : 8);
        chk(spi_mosi_oe == ((k == 0) ? !hz : 1'b0), "R9", {tag, " idle oe"},
            spi_mosi_oe, (k == 0) ? !hz : 1'b0);
        if (k == 0 && !hz)
            chk(spi_mosi == d[0], "R9", {tag, " held last bit"}, spi_mosi, d[0]);
        bus_read(A_CTRL, r);
        chk(r[3:1] == 3'b000, "R5", {tag, " strobes read 0"}, r[3:1], 0);
        chk(r[15:8] == dv[7:0], "R7", {tag, " div unchanged"}, r[15:8], dv);
        chk(spi_cs_n == 1'b0, "R10", {tag, " cs held"}, spi_cs_n, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0017));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_CTRL, r); chk(r == 0, "R1", "ctrl reset", r, 0);
        bus_read(A_STAT, r); chk(r == 0, "R1", "status reset", r, 0);
        bus_read(A_DATA, r); chk(r == 0, "R1", "data reset", r, 0);
        chk(spi_cs_n == 1'b1, "R1", "cs_n reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "sclk reset", spi_sclk, 0);
        chk(spi_mosi_oe == 1'b1, "R1", "oe reset", spi_mosi_oe, 1);

        // R2 upper data bits
        bus_write(A_DATA, 32'hFFFF_FFA5);
        bus_read(A_DATA, r); chk(r == 32'hA5, "R2", "data width", r, 32'hA5);

        // R10 chip select level, R3 zero strobes start nothing
        bus_write(A_CTRL, 32'h1);
        chk(spi_cs_n == 1'b0, "R10", "cs asserted", spi_cs_n, 0);
        bus_write(A_CTRL, 32'h0000_0300);
        repeat (3) @(negedge clk);
        bus_read(A_STAT, r); chk(r == 0, "R3", "no start on zero strobes", r, 0);
        chk(spi_cs_n == 1'b1, "R10", "cs negated", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R3", "sclk idle", spi_sclk, 0);

        // Directed transfers
        do_xfer(3'b001, 8'hC3, 16'h0000, 0, 1'b0, 1'b0, "R3 write div0");
        do_xfer(3'b010, 8'h00, 16'h9E00, 1, 1'b1, 1'b0, "R4 read div1");
        do_xfer(3'b100, 8'h81, 16'hFF5C, 2, 1'b0, 1'b0, "R13 combined div2");
        do_xfer(3'b011, 8'h6D, 16'hF00F, 0, 1'b1, 1'b0, "R12 write beats read");
        do_xfer(3'b111, 8'h17, 16'h33A4, 1, 1'b0, 1'b0, "R12 combined beats all");
        do_xfer(3'b001, 8'hB2, 16'h0000, 3, 1'b0, 1'b1, "R11 poke during write");
        do_xfer(3'b010, 8'h44, 16'h7100, 1, 1'b0, 1'b1, "R11 poke during read");

        // Randomized transfers
        for (int i = 0; i < 24; i++) begin
            logic [3:1] sb;
            case ($urandom % 4)
                0: sb = 3'b001;
                1: sb = 3'b010;
                2: sb = 3'b100;
                default: sb = 3'b011;
            endcase
            do_xfer(sb, 8'($urandom), 16'($urandom), int'($urandom % 4),
                    1'($urandom), (i % 5) == 0, "random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule